// File: doc/BRIEF.md
# Coprocessor Power-Domain Power-Up Sequencer

This block is a clocked controller that brings a switchable SIMD coprocessor power domain out of power-down while the main processor keeps running. Software first turns off its own access to the coprocessor. It then raises a request saying it is safe to power the domain up. The sequencer switches the supply on and waits for the switch to report power-good. It then lets the domain out of reset, and waits a guaranteed minimum number of core clock cycles so the domain can finish its internal reset. Only after that does it drop the output-isolation clamp. Finally it raises a ready status, which software polls before it re-enables access to the coprocessor.

Ready stays high until software asks for power-down. The block then undoes the steps in reverse order: it lowers ready and clamps the outputs, then asserts the domain reset, then removes power. The power-good input comes from an analog switch, so it passes through a synchronizer whose depth is a parameter. All outputs are registered. The design uses a synchronous active-high reset.

Top module: `simd_pwr_seq`

## Requirements
- R1: After the global reset `rst`, the outputs are `pwr_en_o`=0, `dom_rst_n_o`=0, `clamp_o`=1 and `ready_o`=0.
- R2: While powered down, a high `pwrup_req_i` at a rising edge sets `pwr_en_o` to 1 at that edge. `dom_rst_n_o` stays 0, `clamp_o` stays 1 and `ready_o` stays 0.
- R3: `dom_rst_n_o` is 0 whenever `pwr_en_o` is 0. It also stays 0 for as long as power-good has not arrived, however long that takes.
- R4: `dom_rst_n_o` goes to 1 at the edge that is SYNC_STAGES edges after the first edge at which `pwr_good_i` is sampled high.
- R5: `clamp_o` falls exactly WAIT rising edges after the edge at which `dom_rst_n_o` rose. WAIT = max(RST_CYC, 20), so any RST_CYC below 20 behaves as 20.
- R6: `ready_o` rises on the edge after `clamp_o` falls. `ready_o` is only ever high while `clamp_o`=0, `dom_rst_n_o`=1 and `pwr_en_o`=1.
- R7: `pwrup_req_i` or `pwrdn_req_i` raised while a power-up is in progress does not change any output or its timing. `pwrup_req_i` raised while ready has no effect.
- R8: `ready_o` stays 1 until `pwrdn_req_i` is sampled high. At that edge `ready_o` goes to 0 and `clamp_o` to 1. One edge later `dom_rst_n_o` goes to 0. One edge after that `pwr_en_o` goes to 0.
- R9: `pwrdn_req_i` while powered down has no effect. After a power-down, a new `pwrup_req_i` runs the whole sequence again with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high global reset |
| pwrup_req_i | input | 1 | Software: safe to power the domain up |
| pwrdn_req_i | input | 1 | Software: power the domain down |
| pwr_good_i | input | 1 | Asynchronous power-good from the supply switch |
| pwr_en_o | output | 1 | Supply switch enable |
| dom_rst_n_o | output | 1 | Active-low domain reset |
| clamp_o | output | 1 | Output-isolation clamp, 1 = clamped |
| ready_o | output | 1 | Status polled by software: coprocessor may be enabled |

## Verification
The bench repeats the full power-up and power-down cycle while sweeping the power-good delay and the request noise.

**Reset-wait boundary.** It runs one instance whose RST_CYC is below the floor of 20 and one whose RST_CYC is above it, and counts edges from reset release to clamp release on each. An off-by-one counter would release the clamp one edge early or late. An instance that ignored the floor would release its clamp after only 3 edges.

**Power-good synchronizer.** It checks the exact edge at which reset is released. A design that skipped the synchronizer, or took the raw power-good, would release reset too early.

**Ignored requests and power-down ordering.** Requests raised in the middle of a sequence must change nothing; a design that re-armed on them would restart or stall. Requests raised in the wrong state must also change nothing. On power-down, each step is checked on its own edge. A design that collapsed the steps into one edge would drop power while the outputs were still unclamped.

// File: rtl/simd_pwr_pkg.sv
package simd_pwr_pkg;

  localparam int unsigned MIN_RST_CYC = 20;

  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_PWR_ON    = 3'd1,
    ST_RST_WAIT  = 3'd2,
    ST_CLAMP_REL = 3'd3,
    ST_READY     = 3'd4,
    ST_DN_CLAMP  = 3'd5,
    ST_DN_RST    = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic pwr_en;
    logic dom_rst_n;
    logic clamp;
    logic ready;
  } dom_ctl_t;

  localparam dom_ctl_t CTL_RESET = '{pwr_en: 1'b0, dom_rst_n: 1'b0, clamp: 1'b1, ready: 1'b0};

  function automatic int unsigned eff_wait(input int unsigned req_cyc);
    return (req_cyc < MIN_RST_CYC) ? MIN_RST_CYC : req_cyc;
  endfunction

  function automatic dom_ctl_t ctl_for(input seq_state_e st);
    dom_ctl_t c;
    c = CTL_RESET;
    case (st)
      ST_OFF:       c = CTL_RESET;
      ST_PWR_ON:    c = '{pwr_en: 1'b1, dom_rst_n: 1'b0, clamp: 1'b1, ready: 1'b0};
      ST_RST_WAIT:  c = '{pwr_en: 1'b1, dom_rst_n: 1'b1, clamp: 1'b1, ready: 1'b0};
      ST_CLAMP_REL: c = '{pwr_en: 1'b1, dom_rst_n: 1'b1, clamp: 1'b0, ready: 1'b0};
      ST_READY:     c = '{pwr_en: 1'b1, dom_rst_n: 1'b1, clamp: 1'b0, ready: 1'b1};
      ST_DN_CLAMP:  c = '{pwr_en: 1'b1, dom_rst_n: 1'b1, clamp: 1'b1, ready: 1'b0};
      ST_DN_RST:    c = '{pwr_en: 1'b1, dom_rst_n: 1'b0, clamp: 1'b1, ready: 1'b0};
      default:      c = CTL_RESET;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sh_q <= '0;
        end else if (STAGES == 1) begin
          sh_q <= d_i;
        end else begin
          sh_q <= {sh_q[STAGES-2:0], d_i};
        end
      end
      assign q_o = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pwr_rst_timer.sv
module pwr_rst_timer #(
  parameter int unsigned WAIT = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic done_o
);

  localparam int unsigned CW = $clog2(WAIT + 1) + 1;

  logic [CW-1:0] cnt_q;

  // Counts edges spent in the reset-wait state; clears whenever idle.
  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = run_i && (cnt_q == CW'(WAIT - 1));

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import simd_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pwrup_req_i,
  input  logic       pwrdn_req_i,
  input  logic       pg_sync_i,
  input  logic       wait_done_i,
  output seq_state_e state_q_o,
  output seq_state_e state_d_o
);

  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_OFF:       if (pwrup_req_i) st_d = ST_PWR_ON;
      ST_PWR_ON:    if (pg_sync_i)   st_d = ST_RST_WAIT;
      ST_RST_WAIT:  if (wait_done_i) st_d = ST_CLAMP_REL;
      ST_CLAMP_REL: st_d = ST_READY;
      ST_READY:     if (pwrdn_req_i) st_d = ST_DN_CLAMP;
      ST_DN_CLAMP:  st_d = ST_DN_RST;
      ST_DN_RST:    st_d = ST_OFF;
      default:      st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_OFF;
    else     st_q <= st_d;
  end

  assign state_q_o = st_q;
  assign state_d_o = st_d;

endmodule

// File: rtl/pwr_out_reg.sv
module pwr_out_reg
  import simd_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_e state_d_i,
  output dom_ctl_t   ctl_o
);

  dom_ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= CTL_RESET;
    else     ctl_q <= ctl_for(state_d_i);
  end

  assign ctl_o = ctl_q;

endmodule

// File: rtl/simd_pwr_seq.sv
module simd_pwr_seq
  import simd_pwr_pkg::*;
#(
  parameter int unsigned RST_CYC     = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwrup_req_i,
  input  logic pwrdn_req_i,
  input  logic pwr_good_i,
  output logic pwr_en_o,
  output logic dom_rst_n_o,
  output logic clamp_o,
  output logic ready_o
);

  localparam int unsigned WAIT = eff_wait(RST_CYC);

  logic       pg_sync;
  logic       wait_done;
  seq_state_e st_q, st_d;
  dom_ctl_t   ctl;

  pwr_sync #(.STAGES(SYNC_STAGES)) u_pg_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pwr_good_i),
    .q_o (pg_sync)
  );

  pwr_rst_timer #(.WAIT(WAIT)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run_i  (st_q == ST_RST_WAIT),
    .done_o (wait_done)
  );

  pwr_seq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .pwrup_req_i (pwrup_req_i),
    .pwrdn_req_i (pwrdn_req_i),
    .pg_sync_i   (pg_sync),
    .wait_done_i (wait_done),
    .state_q_o   (st_q),
    .state_d_o   (st_d)
  );

  pwr_out_reg u_out (
    .clk       (clk),
    .rst       (rst),
    .state_d_i (st_d),
    .ctl_o     (ctl)
  );

  assign pwr_en_o    = ctl.pwr_en;
  assign dom_rst_n_o = ctl.dom_rst_n;
  assign clamp_o     = ctl.clamp;
  assign ready_o     = ctl.ready;

endmodule

// File: rtl/simd_pwr_seq_chk.sv
module simd_pwr_seq_chk
  import simd_pwr_pkg::*;
#(
  parameter int unsigned RST_CYC = 20
) (
  input logic clk,
  input logic rst,
  input logic pwrdn_req_i,
  input logic pwr_en_o,
  input logic dom_rst_n_o,
  input logic clamp_o,
  input logic ready_o
);

  localparam int unsigned WAIT = eff_wait(RST_CYC);
  localparam int unsigned CW   = $clog2(WAIT + 2) + 1;

  logic [CW-1:0] since_rel_q;
  logic          rst_seen_q;

  always_ff @(posedge clk) begin
    if (rst || !dom_rst_n_o)  since_rel_q <= '0;
    else if (clamp_o)         since_rel_q <= since_rel_q + 1'b1;
    rst_seen_q <= rst;
  end

  always_ff @(posedge clk) begin
    if (rst_seen_q) begin
      p_reset_state_r1: assert (!pwr_en_o && !dom_rst_n_o && clamp_o && !ready_o)
        else $error("reset state wrong");
    end
  end

  p_rst_while_off_r3: assert property (@(posedge clk) disable iff (rst)
    !pwr_en_o |-> !dom_rst_n_o);

  p_power_first_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(dom_rst_n_o) |-> $past(pwr_en_o));

  p_clamp_wait_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(clamp_o) |-> (since_rel_q == CW'(WAIT)));

  p_ready_safe_r6: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (!clamp_o && dom_rst_n_o && pwr_en_o));

  p_ready_follows_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(clamp_o) |=> ready_o);

  p_ready_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !pwrdn_req_i) |=> ready_o);

  p_dn_clamp_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_o) |-> (clamp_o && $past(pwrdn_req_i)));

  p_dn_power_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en_o) |-> $past(!dom_rst_n_o && clamp_o));

endmodule

bind simd_pwr_seq simd_pwr_seq_chk #(.RST_CYC(RST_CYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pwrdn_req_i (pwrdn_req_i),
  .pwr_en_o    (pwr_en_o),
  .dom_rst_n_o (dom_rst_n_o),
  .clamp_o     (clamp_o),
  .ready_o     (ready_o)
);

// File: tb/tb_simd_pwr_seq.sv
module tb_simd_pwr_seq;

  localparam int unsigned SYNC   = 2;
  localparam int unsigned RC_A   = 24;
  localparam int unsigned RC_B   = 3;
  localparam int unsigned WAIT_A = (RC_A < 20) ? 20 : RC_A;
  localparam int unsigned WAIT_B = (RC_B < 20) ? 20 : RC_B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up = 1'b0, dn = 1'b0, pg = 1'b0;
  logic en_a, rn_a, cl_a, rd_a;
  logic en_b, rn_b, cl_b, rd_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  simd_pwr_seq #(.RST_CYC(RC_A), .SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst(rst), .pwrup_req_i(up), .pwrdn_req_i(dn), .pwr_good_i(pg),
    .pwr_en_o(en_a), .dom_rst_n_o(rn_a), .clamp_o(cl_a), .ready_o(rd_a));

  simd_pwr_seq #(.RST_CYC(RC_B), .SYNC_STAGES(SYNC)) dut_floor (
    .clk(clk), .rst(rst), .pwrup_req_i(up), .pwrdn_req_i(dn), .pwr_good_i(pg),
    .pwr_en_o(en_b), .dom_rst_n_o(rn_b), .clamp_o(cl_b), .ready_o(rd_b));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // outputs packed {pwr_en, rst_n, clamp, ready}
  task automatic chk_both(input string req, input int exp);
    chk({req, " main"},  {en_a, rn_a, cl_a, rd_a}, exp);
    chk({req, " floor"}, {en_b, rn_b, cl_b, rd_b}, exp);
  endtask

  task automatic cycle_once(input int gdelay, input bit noise);
    int fall_a, fall_b, rdy_a, rdy_b;
    // R2: request accepted from power-down
    up = 1'b1;
    tick();
    up = 1'b0;
    chk_both("R2 power enable on request", 4'b1010);
    // R3/R7: waiting for power-good; requests are noise
    for (int i = 0; i < gdelay; i++) begin
      up = noise; dn = noise;
      tick();
    end
    up = 1'b0; dn = 1'b0;
    chk_both("R3 reset held before power-good", 4'b1010);
    // R4: synchronized power-good
    pg = 1'b1;
    for (int i = 0; i < int'(SYNC); i++) tick();
    chk_both("R4 reset still held during sync", 4'b1010);
    tick();
    chk_both("R4 reset released", 4'b1110);
    // R5/R6/R7: count edges to clamp release and ready
    fall_a = -1; fall_b = -1; rdy_a = -1; rdy_b = -1;
    for (int i = 1; i <= 30; i++) begin
      up = noise && (i < 6);
      dn = noise && (i > 2) && (i < 8);
      tick();
      if (fall_a < 0 && !cl_a) fall_a = i;
      if (fall_b < 0 && !cl_b) fall_b = i;
      if (rdy_a < 0 && rd_a) rdy_a = i;
      if (rdy_b < 0 && rd_b) rdy_b = i;
    end
    up = 1'b0; dn = 1'b0;
    chk("R5 clamp wait main", fall_a, int'(WAIT_A));
    chk("R5 clamp wait floor", fall_b, int'(WAIT_B));
    chk("R6 ready after clamp main", rdy_a, int'(WAIT_A) + 1);
    chk("R6 ready after clamp floor", rdy_b, int'(WAIT_B) + 1);
    // R7: request while ready
    up = 1'b1;
    tick();
    up = 1'b0;
    chk_both("R7 request while ready ignored", 4'b1101);
    // R8: ready holds, then ordered power-down
    tick(); tick();
    chk_both("R8 ready holds", 4'b1101);
    dn = 1'b1;
    tick();
    dn = 1'b0;
    chk_both("R8 down step clamp", 4'b1110);
    tick();
    chk_both("R8 down step reset", 4'b1010);
    pg = 1'b0;
    tick();
    chk_both("R8 down step power", 4'b0010);
    // R9: power-down request while off
    dn = 1'b1;
    tick(); tick();
    dn = 1'b0;
    chk_both("R9 down request while off ignored", 4'b0010);
    for (int i = 0; i < 4; i++) tick();
  endtask

  initial begin
    rst = 1'b1;
    for (int i = 0; i < 4; i++) tick();
    rst = 1'b0;
    chk_both("R1 reset state", 4'b0010);
    tick();
    chk_both("R1 idle after reset", 4'b0010);
    // R9: repeated cycles reuse the same timing
    cycle_once(0, 1'b0);
    cycle_once(1, 1'b1);
    cycle_once(3, 1'b0);
    cycle_once(7, 1'b1);
    cycle_once(40, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule